// File: doc/BRIEF.md
# Vectored Interrupt and Trap Entry Unit

This unit sits next to a small processor's fetch stage. It collects hardware interrupt requests from device controllers and software trap requests (an error trap and a deliberate service-call trap). When it takes one, it records the address of the interrupted instruction and the privilege mode in force. It then forces monitor mode and redirects fetch to a handler address read from an eight-entry vector table. The table holds one address per source.

Once an entry is taken, the unit masks further entries until the handler issues a return strobe. The return sends fetch back to the saved address and restores the saved mode. Requests that arrive while masked are held as pending bits and are taken one by one after each return. The vector table can only be written while the processor is in monitor mode. Nested entry and register-file saving are not part of this block.

Top module: `irq_entry`

## Requirements
- R1: After reset, redirectValid is 0, userMode is 0 (monitor), intMasked is 0 and every vector entry reads 0.
- R2: A request sampled at a clock edge while intMasked is 0 produces, in the following cycle, redirectValid = 1 for one cycle. In that cycle redirectPc is the vector entry of the source and causeIdx is its index. Source index 0 is trapErr, index 1 is trapCall and index 2+i is irqReq[i].
- R3: Among requests present together, the lowest source index is taken, so a trap always wins over any hardware request.
- R4: The redirect issued by a return carries the curPc value sampled at the edge where the entry was taken.
- R5: Taking an entry sets intMasked. Requests arriving while masked are not taken until a return strobe. The lowest pending one is then taken at the edge after the return edge, so the return redirect and the new entry redirect appear in consecutive cycles.
- R6: Taking an entry forces userMode to 0. A return restores the mode that was in force before the entry. enterUser sets userMode to 1 when it arrives in monitor mode.
- R7: A vector write (vecWe, vecIdx, vecData) takes effect only when userMode is 0. In user mode it leaves the table unchanged.
- R8: retStrobe while intMasked is 0 has no effect: there is no redirect and no change of mode.
- R9: Repeated requests from one source while masked merge into a single pending entry. Each pending source is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_IRQ | Hardware request pulses, one per device |
| trapErr | input | 1 | Error trap request (source 0) |
| trapCall | input | 1 | Service-call trap request (source 1) |
| curPc | input | ADDR_W | Address of the instruction that would be interrupted |
| retStrobe | input | 1 | Handler return strobe |
| enterUser | input | 1 | Request to drop to user mode |
| vecWe | input | 1 | Vector table write enable |
| vecIdx | input | IDX_W | Vector table write index |
| vecData | input | ADDR_W | Vector table write data |
| redirectValid | output | 1 | Fetch redirect strobe |
| redirectPc | output | ADDR_W | Fetch redirect address |
| causeIdx | output | IDX_W | Source index of the last taken entry |
| userMode | output | 1 | 1 = user mode, 0 = monitor mode |
| intMasked | output | 1 | Entry in progress; new entries held off |

## Verification
The hardest situation to reach is a set of pending requests draining after a return. In that case the return redirect and the next entry redirect appear in back-to-back cycles, and the return address of the first entry must not leak into the second. The bench reaches it by raising every ordered pair of sources in the same cycle. One source wins and the other waits pending, and the bench then walks both returns. In a separate sequence it pulses sources several times inside a handler to show that repeated pulses merge.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic {
    MODE_MONITOR = 1'b0,
    MODE_USER    = 1'b1
  } privMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // enter a handler this edge
    logic ret;    // return from handler this edge
    logic wrVec;  // honoured vector table write
  } ctrlStrobe_t;

  localparam int unsigned NUM_TRAP = 2;

endpackage

// File: rtl/irq_entry_arb.sv
module irq_entry_arb #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          anyReq,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grantIdx
);

  logic [N:0] lowerSeen;
  assign lowerSeen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]         = req[i] & ~lowerSeen[i];
    assign lowerSeen[i + 1] = lowerSeen[i] | req[i];
  end

  assign anyReq = lowerSeen[N];

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) grantIdx = grantIdx | IW'(i);
    end
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IW    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DEPTH-1:0] reqVec,
  input  logic             retStrobe,
  input  logic             enterUser,
  input  logic             vecWe,
  output ctrlStrobe_t      strobe,
  output logic [IW-1:0]    grantIdx,
  output logic             userMode,
  output logic             intMasked
);

  logic [DEPTH-1:0] pendQ;
  logic [DEPTH-1:0] allReq;
  logic [DEPTH-1:0] grant;
  logic             anyReq;
  logic             maskQ;
  privMode_e        modeQ;
  privMode_e        savedModeQ;

  assign allReq = pendQ | reqVec;

  irq_entry_arb #(.N(DEPTH), .IW(IW)) u_arb (
    .req      (allReq),
    .anyReq   (anyReq),
    .grant    (grant),
    .grantIdx (grantIdx)
  );

  always_comb begin
    strobe.take  = ~maskQ & anyReq;
    strobe.ret   = maskQ & retStrobe;
    strobe.wrVec = vecWe & (modeQ == MODE_MONITOR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ      <= '0;
      maskQ      <= 1'b0;
      modeQ      <= MODE_MONITOR;
      savedModeQ <= MODE_MONITOR;
    end else begin
      pendQ <= strobe.take ? (allReq & ~grant) : allReq;
      if (strobe.take) begin
        maskQ      <= 1'b1;
        savedModeQ <= modeQ;
        modeQ      <= MODE_MONITOR;
      end else if (strobe.ret) begin
        maskQ <= 1'b0;
        modeQ <= savedModeQ;
      end else if (enterUser && modeQ == MODE_MONITOR) begin
        modeQ <= MODE_USER;
      end
    end
  end

  assign userMode  = (modeQ == MODE_USER);
  assign intMasked = maskQ;

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp
  import irq_entry_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned IW     = 3,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [IW-1:0]     grantIdx,
  input  logic [ADDR_W-1:0] curPc,
  input  logic [IW-1:0]     vecIdx,
  input  logic [ADDR_W-1:0] vecData,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectPc,
  output logic [IW-1:0]     causeIdx
);

  logic [ADDR_W-1:0] vecQ [DEPTH];
  logic [ADDR_W-1:0] savedPcQ;
  logic [DEPTH-1:0]  wrSel;

  for (genvar i = 0; i < DEPTH; i++) begin : g_vec
    assign wrSel[i] = strobe.wrVec && (vecIdx == IW'(i));
    always_ff @(posedge clk) begin
      if (!rstN)         vecQ[i] <= '0;
      else if (wrSel[i]) vecQ[i] <= vecData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      savedPcQ      <= '0;
      redirectValid <= 1'b0;
      redirectPc    <= '0;
      causeIdx      <= '0;
    end else begin
      redirectValid <= strobe.take | strobe.ret;
      if (strobe.take) begin
        savedPcQ   <= curPc;
        redirectPc <= vecQ[grantIdx];
        causeIdx   <= grantIdx;
      end else if (strobe.ret) begin
        redirectPc <= savedPcQ;
      end
    end
  end

endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 6,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned DEPTH  = NUM_IRQ + NUM_TRAP,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               trapErr,
  input  logic               trapCall,
  input  logic [ADDR_W-1:0]  curPc,
  input  logic               retStrobe,
  input  logic               enterUser,
  input  logic               vecWe,
  input  logic [IDX_W-1:0]   vecIdx,
  input  logic [ADDR_W-1:0]  vecData,
  output logic               redirectValid,
  output logic [ADDR_W-1:0]  redirectPc,
  output logic [IDX_W-1:0]   causeIdx,
  output logic               userMode,
  output logic               intMasked
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] grantIdx;
  logic [DEPTH-1:0] reqVec;

  // source order sets priority: error trap, service-call trap, devices
  assign reqVec = {irqReq, trapCall, trapErr};

  irq_entry_ctrl #(.DEPTH(DEPTH), .IW(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqVec    (reqVec),
    .retStrobe (retStrobe),
    .enterUser (enterUser),
    .vecWe     (vecWe),
    .strobe    (strobe),
    .grantIdx  (grantIdx),
    .userMode  (userMode),
    .intMasked (intMasked)
  );

  irq_entry_dp #(.DEPTH(DEPTH), .IW(IDX_W), .ADDR_W(ADDR_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .grantIdx      (grantIdx),
    .curPc         (curPc),
    .vecIdx        (vecIdx),
    .vecData       (vecData),
    .redirectValid (redirectValid),
    .redirectPc    (redirectPc),
    .causeIdx      (causeIdx)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              retStrobe,
  input logic [ADDR_W-1:0] curPc,
  input logic              redirectValid,
  input logic [ADDR_W-1:0] redirectPc,
  input logic              userMode,
  input logic              intMasked
);

  logic              maskPrev;
  logic              modePrev;
  logic [ADDR_W-1:0] pcPrev;
  logic [ADDR_W-1:0] heldPc;
  logic              heldMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskPrev <= 1'b0;
      modePrev <= 1'b0;
      pcPrev   <= '0;
      heldPc   <= '0;
      heldMode <= 1'b0;
    end else begin
      maskPrev <= intMasked;
      modePrev <= userMode;
      pcPrev   <= curPc;
      if (intMasked && !maskPrev) begin
        heldPc   <= pcPrev;
        heldMode <= modePrev;
      end
    end
  end

  AST_REDIRECT_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> ($rose(intMasked) || $fell(intMasked))); // R2
  AST_ENTRY_MONITOR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intMasked) |-> !userMode); // R6
  AST_RET_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intMasked) |-> $past(retStrobe)); // R8
  AST_RETURN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intMasked) |-> (redirectPc == heldPc)); // R4
  AST_MODE_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intMasked) |-> (userMode == heldMode)); // R6

endmodule

bind irq_entry irq_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .retStrobe     (retStrobe),
  .curPc         (curPc),
  .redirectValid (redirectValid),
  .redirectPc    (redirectPc),
  .userMode      (userMode),
  .intMasked     (intMasked)
);

// File: tb/irq_entry_bench.sv
module irq_entry_bench;

  localparam int NIRQ = 6;
  localparam int NSRC = NIRQ + 2;
  localparam int AW   = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NIRQ-1:0] irqReq = '0;
  logic          trapErr = 1'b0, trapCall = 1'b0;
  logic [AW-1:0] curPc = '0;
  logic          retStrobe = 1'b0, enterUser = 1'b0, vecWe = 1'b0;
  logic [2:0]    vecIdx = '0;
  logic [AW-1:0] vecData = '0;
  logic          redirectValid;
  logic [AW-1:0] redirectPc;
  logic [2:0]    causeIdx;
  logic          userMode, intMasked;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk; // 50 MHz

  irq_entry u_irq_entry (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .trapErr(trapErr),
    .trapCall(trapCall), .curPc(curPc), .retStrobe(retStrobe),
    .enterUser(enterUser), .vecWe(vecWe), .vecIdx(vecIdx),
    .vecData(vecData), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .causeIdx(causeIdx), .userMode(userMode),
    .intMasked(intMasked)
  );

  function automatic logic [AW-1:0] vecVal(int i);
    return 32'h0000_8000 + AW'(i) * 32'h104;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic raise(input int idx);
    if (idx == 0) trapErr = 1'b1;
    else if (idx == 1) trapCall = 1'b1;
    else irqReq[idx-2] = 1'b1;
  endtask

  task automatic dropAll();
    trapErr = 1'b0; trapCall = 1'b0; irqReq = '0;
    retStrobe = 1'b0; enterUser = 1'b0; vecWe = 1'b0;
  endtask

  // expect an entry redirect for source idx in the current cycle
  task automatic expEntry(input int idx, input string tag);
    check(redirectValid === 1'b1, {tag, " redirectValid"}, AW'(redirectValid), 1);
    check(redirectPc === vecVal(idx), {tag, " redirectPc"}, redirectPc, vecVal(idx));
    check(causeIdx === 3'(idx), {tag, " causeIdx"}, AW'(causeIdx), AW'(idx));
    check(intMasked === 1'b1 && userMode === 1'b0, {tag, " masked/monitor"},
          AW'({intMasked, userMode}), AW'(2'b10));
  endtask

  task automatic doReturn(input logic [AW-1:0] expPc, input logic expMode,
                          input string tag);
    retStrobe = 1'b1;
    curPc = 32'hDEAD_0000;
    step();
    retStrobe = 1'b0;
    check(redirectValid === 1'b1 && redirectPc === expPc, {tag, " return pc"},
          redirectPc, expPc);
    check(intMasked === 1'b0 && userMode === expMode, {tag, " return mode"},
          AW'({intMasked, userMode}), AW'({1'b0, expMode}));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(redirectValid === 1'b0, "R1 redirectValid", AW'(redirectValid), 0);
    check(userMode === 1'b0, "R1 userMode", AW'(userMode), 0);
    check(intMasked === 1'b0, "R1 intMasked", AW'(intMasked), 0);
    rstN = 1'b1;
    step();
    check(redirectValid === 1'b0, "R1 idle after reset", AW'(redirectValid), 0);
    // R1 vector entries read 0 after reset
    raise(4); curPc = 32'h0000_0444;
    step(); dropAll();
    check(redirectValid === 1'b1 && redirectPc === '0, "R1 vector reset value",
          redirectPc, 0);
    doReturn(32'h0000_0444, 1'b0, "R1");

    // R7 monitor writes honoured: load the whole table
    for (int i = 0; i < NSRC; i++) begin
      vecWe = 1'b1; vecIdx = 3'(i); vecData = vecVal(i);
      step();
    end
    vecWe = 1'b0;

    // R2/R3/R4/R5: every ordered pair of sources raised together
    for (int i = 0; i < NSRC; i++) begin
      for (int j = 0; j < NSRC; j++) begin
        automatic int lo = (i < j) ? i : j;
        automatic int hi = (i < j) ? j : i;
        automatic logic [AW-1:0] p1 = 32'h4000_0000 | AW'(i << 8) | AW'(j);
        automatic logic [AW-1:0] p2 = 32'h5000_0000 | AW'(i << 8) | AW'(j);
        raise(i); raise(j); curPc = p1;
        step(); dropAll();
        expEntry(lo, "R2/R3 pair winner");
        doReturn(p1, 1'b0, "R4 pair");
        if (i != j) begin
          curPc = p2;
          step();
          expEntry(hi, "R5 pending taken after return");
          doReturn(p2, 1'b0, "R4 pending");
        end
        step();
        check(redirectValid === 1'b0, "R5 idle after drain", AW'(redirectValid), 0);
      end
    end

    // R9 repeated pulses while masked merge
    raise(2); curPc = 32'h0000_1000;
    step(); dropAll();
    expEntry(2, "R9 first entry");
    for (int k = 0; k < 3; k++) begin
      raise(6); step(); dropAll(); step();
      check(redirectValid === 1'b0 && intMasked === 1'b1, "R5 held off while masked",
            AW'(redirectValid), 0);
    end
    raise(7); step(); dropAll();
    doReturn(32'h0000_1000, 1'b0, "R9");
    curPc = 32'h0000_2000;
    step();
    expEntry(6, "R9 merged source");
    doReturn(32'h0000_2000, 1'b0, "R9");
    curPc = 32'h0000_3000;
    step();
    expEntry(7, "R9 second pending");
    doReturn(32'h0000_3000, 1'b0, "R9");
    for (int k = 0; k < 3; k++) begin
      step();
      check(redirectValid === 1'b0, "R9 no duplicate entry", AW'(redirectValid), 0);
    end

    // R6 drop to user mode
    enterUser = 1'b1; step(); dropAll();
    check(userMode === 1'b1, "R6 enterUser", AW'(userMode), 1);

    // R8 return strobe ignored while unmasked
    retStrobe = 1'b1; step(); dropAll();
    check(redirectValid === 1'b0 && userMode === 1'b1 && intMasked === 1'b0,
          "R8 stray return", AW'({redirectValid, userMode, intMasked}), AW'(3'b010));

    // R7 user-mode write ignored
    vecWe = 1'b1; vecIdx = 3'd3; vecData = 32'hBAD0_BAD0;
    step(); dropAll();
    // R6 entry from user mode forces monitor, return restores user
    raise(3); curPc = 32'h0000_7000;
    step(); dropAll();
    expEntry(3, "R7 user write ignored / R6 entry");
    doReturn(32'h0000_7000, 1'b1, "R6 restore user");

    // R7 monitor write inside handler honoured
    raise(0); curPc = 32'h0000_7100;
    step(); dropAll();
    expEntry(0, "R6 trap from user");
    vecWe = 1'b1; vecIdx = 3'd5; vecData = 32'h1234_5670;
    step(); dropAll();
    doReturn(32'h0000_7100, 1'b1, "R6 trap return");
    check(userMode === 1'b1, "R6 still user", AW'(userMode), 1);
    raise(5); curPc = 32'h0000_7200;
    step(); dropAll();
    check(redirectPc === 32'h1234_5670, "R7 monitor write honoured", redirectPc,
          32'h1234_5670);
    doReturn(32'h0000_7200, 1'b1, "R6");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule